// File: doc/BRIEF.md
# Column-Sorting Multi-Operand Adder

This block adds a set of M unsigned operands, each N bits wide, that arrive together on one wide input and are captured by a single start strobe. Each bit position is handled as its own column. It holds one bit from every operand, and row 0 is operand 0. A row of small exchange cells sits between every pair of neighbouring rows. Each cell acts on its own: when it sees a 0 above a 1, it swaps them. Even and odd pairs take turns on alternating cycles. The ones in each column therefore rise to the top, and the number of ones never changes.

Once no column has a 0 above a 1, every column reads as a thermometer code. A priority encoder turns each column into a count. The counts are shifted by their column index and summed to give the full-width result. The only control logic in the block watches the columns as a whole and notices when all of them have settled, or when the worst-case number of exchange rounds has run. At that point it raises done and presents the result. A new operand set may be started from idle or after a result, but not while a sort is running.

Top module: `msa_adder`

## Requirements
- R1: After reset, busy_o and done_o are low and sum_o is zero.
- R2: A start_i pulse while busy_o is low captures ops_i, where operand j sits at bits [j*OP_W +: OP_W]. On the next cycle busy_o is high and done_o is low. This holds both from idle and while a previous result is shown.
- R3: While done_o is high, sum_o equals the exact unsigned sum of the captured operands.
- R4: sum_o is zero in every cycle in which done_o is low.
- R5: busy_o stays high for at most N_OPS+1 consecutive cycles.
- R6: If no column of the captured set has a 0 in a lower-numbered row above a 1 in a higher-numbered row, busy_o lasts exactly one cycle. Examples are all operands equal or all operands zero. An all-zero column counts as zero.
- R7: A start_i pulse while busy_o is high is ignored. The result is that of the set already being sorted.
- R8: busy_o and done_o are never high together. done_o and sum_o hold their values until the next accepted start.
- R9: sum_o is OP_W+CNT_W bits wide, where CNT_W is the smallest width with N_OPS < 2^CNT_W. The largest possible sum, N_OPS*(2^OP_W-1), appears without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Capture ops_i and begin sorting (honoured only while not busy) |
| ops_i | input | N_OPS*OP_W | Operand array, operand j at bits [j*OP_W +: OP_W] |
| busy_o | output | 1 | Columns are being sorted |
| done_o | output | 1 | Result on sum_o is valid |
| sum_o | output | OP_W+CNT_W | Sum of all operands, zero unless done_o is high |

## Verification
The two events that can fall in the same cycle are a new start strobe and an exchange step of a sort that is still running. The directed test raises start_i with a second operand set one cycle into a sort of a slow, bottom-heavy pattern. It then judges the case by the final sum, which must belong to the first set, and by busy_o, which must end within the normal bound. A second pairing is a start strobe in the same cycle that done_o is showing. That start must be accepted, and on the next edge it must clear both done_o and sum_o.

// File: rtl/msa_pkg.sv
package msa_pkg;

   typedef enum logic [1:0] {
      MSA_IDLE = 2'd0,
      MSA_SORT = 2'd1,
      MSA_DONE = 2'd2
   } msa_state_e;

   // smallest width w with m < 2**w, i.e. 2**(w-1) <= m < 2**w
   function automatic int cnt_width(input int m);
      return $clog2(m + 1);
   endfunction

endpackage

// File: rtl/msa_xchg_cell.sv
// One local compare-exchange element between row r (upper) and row r+1 (lower).
// It decides its own swap; nothing outside tells it which rows to exchange.
module msa_xchg_cell #(
   parameter int PARITY = 0
) (
   input  logic upper_i,
   input  logic lower_i,
   input  logic step_i,
   input  logic phase_i,
   output logic swap_o,
   output logic disorder_o
);

   logic my_turn;

   generate
      if (PARITY != 0 && PARITY != 1) begin : g_bad_parity
         $error("msa_xchg_cell: PARITY must be 0 or 1");
      end
   endgenerate

   assign my_turn    = step_i && (phase_i == (PARITY != 0));
   assign disorder_o = !upper_i && lower_i;
   assign swap_o     = my_turn && disorder_o;

endmodule

// File: rtl/msa_column.sv
// Holds one bit column and bubbles its ones toward row 0. It also reports whether
// any pair is still out of order and encodes the settled thermometer pattern.
module msa_column #(
   parameter int ROWS  = 8,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [ROWS-1:0]  bits_i,
   input  logic             step_i,
   input  logic             phase_i,
   output logic             disorder_o,
   output logic [CNT_W-1:0] count_o
);

   localparam int PAIRS = ROWS - 1;

   logic [ROWS-1:0]  row_q;
   logic [ROWS-1:0]  row_d;
   logic [PAIRS-1:0] swap;
   logic [PAIRS-1:0] dis;

   generate
      if (ROWS < 2) begin : g_bad_rows
         $error("msa_column: ROWS must be at least 2");
      end
      if ((1 << CNT_W) <= ROWS) begin : g_bad_cnt
         $error("msa_column: CNT_W too narrow for ROWS");
      end
   endgenerate

   // exchange cells, parity chosen by pair index
   generate
      for (genvar p = 0; p < PAIRS; p++) begin : g_pair
         msa_xchg_cell #(
            .PARITY(p % 2)
         ) u_cell (
            .upper_i   (row_q[p]),
            .lower_i   (row_q[p+1]),
            .step_i    (step_i),
            .phase_i   (phase_i),
            .swap_o    (swap[p]),
            .disorder_o(dis[p])
         );
      end
   endgenerate

   // next value of every row: a swap below sets it, a swap above clears it
   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         if (r == 0) begin : g_top
            assign row_d[r] = swap[r] ? 1'b1 : row_q[r];
         end else if (r == ROWS - 1) begin : g_bottom
            assign row_d[r] = swap[r-1] ? 1'b0 : row_q[r];
         end else begin : g_mid
            assign row_d[r] = swap[r]   ? 1'b1 :
                              swap[r-1] ? 1'b0 : row_q[r];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= '0;
      end else if (load_i) begin
         row_q <= bits_i;
      end else if (step_i) begin
         row_q <= row_d;
      end
   end

   assign disorder_o = |dis;

   // thermometer to binary: position of the deepest one, counted from 1
   always_comb begin
      count_o = '0;
      for (int r = 0; r < ROWS; r++) begin
         if (row_q[r]) begin
            count_o = CNT_W'(r + 1);
         end
      end
   end

endmodule

// File: rtl/msa_weight_sum.sv
// Adds every column count after shifting it left by its column index.
module msa_weight_sum #(
   parameter int COLS  = 8,
   parameter int CNT_W = 4,
   parameter int SUM_W = 12
) (
   input  logic [COLS-1:0][CNT_W-1:0] counts_i,
   output logic [SUM_W-1:0]           sum_o
);

   generate
      if (SUM_W < COLS + CNT_W - 1) begin : g_bad_sum
         $error("msa_weight_sum: SUM_W too narrow");
      end
   endgenerate

   always_comb begin
      sum_o = '0;
      for (int c = 0; c < COLS; c++) begin
         sum_o = sum_o + (SUM_W'(counts_i[c]) << c);
      end
   end

endmodule

// File: rtl/msa_adder.sv
module msa_adder
   import msa_pkg::*;
#(
   parameter  int N_OPS = 8,
   parameter  int OP_W  = 8,
   localparam int CNT_W = cnt_width(N_OPS),
   localparam int SUM_W = OP_W + CNT_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic [N_OPS*OP_W-1:0] ops_i,
   output logic                  busy_o,
   output logic                  done_o,
   output logic [SUM_W-1:0]      sum_o
);

   localparam int STEP_W = $clog2(N_OPS + 1);

   generate
      if (N_OPS < 2) begin : g_bad_ops
         $error("msa_adder: N_OPS must be at least 2");
      end
      if (OP_W < 1) begin : g_bad_width
         $error("msa_adder: OP_W must be at least 1");
      end
      if ((1 << (CNT_W - 1)) > N_OPS || N_OPS >= (1 << CNT_W)) begin : g_bad_cnt
         $error("msa_adder: CNT_W does not bracket N_OPS");
      end
   endgenerate

   msa_state_e                   state_q;
   logic                         phase_q;
   logic [STEP_W-1:0]            step_q;
   logic [SUM_W-1:0]             sum_q;

   logic                         load;
   logic                         settled;
   logic                         step;
   logic [OP_W-1:0]              col_dis;
   logic [OP_W-1:0][CNT_W-1:0]   col_cnt;
   logic [OP_W-1:0][N_OPS-1:0]   col_bits;
   logic [SUM_W-1:0]             acc;

   // transpose operands into columns: column c, row j = bit c of operand j
   generate
      for (genvar c = 0; c < OP_W; c++) begin : g_tr_col
         for (genvar j = 0; j < N_OPS; j++) begin : g_tr_row
            assign col_bits[c][j] = ops_i[j*OP_W + c];
         end
      end
   endgenerate

   assign load    = start_i && (state_q != MSA_SORT);
   assign settled = !(|col_dis) || (step_q == STEP_W'(N_OPS));
   assign step    = (state_q == MSA_SORT) && !settled;

   generate
      for (genvar c = 0; c < OP_W; c++) begin : g_col
         msa_column #(
            .ROWS (N_OPS),
            .CNT_W(CNT_W)
         ) u_column (
            .clk       (clk),
            .rst_n     (rst_n),
            .load_i    (load),
            .bits_i    (col_bits[c]),
            .step_i    (step),
            .phase_i   (phase_q),
            .disorder_o(col_dis[c]),
            .count_o   (col_cnt[c])
         );
      end
   endgenerate

   msa_weight_sum #(
      .COLS (OP_W),
      .CNT_W(CNT_W),
      .SUM_W(SUM_W)
   ) u_weight_sum (
      .counts_i(col_cnt),
      .sum_o   (acc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MSA_IDLE;
         phase_q <= 1'b0;
         step_q  <= '0;
         sum_q   <= '0;
      end else begin
         unique case (state_q)
            MSA_IDLE, MSA_DONE: begin
               if (load) begin
                  state_q <= MSA_SORT;
                  phase_q <= 1'b0;
                  step_q  <= '0;
                  sum_q   <= '0;
               end
            end
            MSA_SORT: begin
               if (settled) begin
                  state_q <= MSA_DONE;
                  sum_q   <= acc;
               end else begin
                  phase_q <= !phase_q;
                  step_q  <= step_q + 1'b1;
               end
            end
            default: begin
               state_q <= MSA_IDLE;
            end
         endcase
      end
   end

   assign busy_o = (state_q == MSA_SORT);
   assign done_o = (state_q == MSA_DONE);
   assign sum_o  = sum_q;

endmodule

// File: rtl/msa_adder_chk.sv
module msa_adder_chk #(
   parameter int M     = 8,
   parameter int SUM_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             busy_o,
   input logic             done_o,
   input logic [SUM_W-1:0] sum_o
);

   int unsigned busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) busy_run <= 0;
      else if (busy_o) busy_run <= busy_run + 1;
      else busy_run <= 0;
   end

   a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_o && done_o));

   a_r4_sum_zero_unless_done: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> (sum_o == '0));

   a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !start_i) |=> (done_o && $stable(sum_o)));

   a_r2_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o) |=> (busy_o && !done_o));

   a_r7_start_in_sort_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (busy_o || done_o));

   a_r5_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (busy_run <= M));

endmodule

bind msa_adder msa_adder_chk #(
   .M    (N_OPS),
   .SUM_W(SUM_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start_i(start_i),
   .busy_o (busy_o),
   .done_o (done_o),
   .sum_o  (sum_o)
);

// File: tb/msa_adder_tb.sv
module msa_adder_tb;

   localparam int M  = 8;
   localparam int N  = 8;
   localparam int CW = 4;
   localparam int SW = N + CW;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start_i = 1'b0;
   logic [M*N-1:0] ops_i = '0;
   logic           busy_o;
   logic           done_o;
   logic [SW-1:0]  sum_o;

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 0;

   always #4 clk = !clk;

   msa_adder #(.N_OPS(M), .OP_W(N)) u_dut (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(start_i),
      .ops_i  (ops_i),
      .busy_o (busy_o),
      .done_o (done_o),
      .sum_o  (sum_o)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic longint ref_sum(input logic [M-1:0][N-1:0] v);
      longint s = 0;
      for (int j = 0; j < M; j++) s += longint'(v[j]);
      return s;
   endfunction

   // start a set, wait for done; returns number of busy cycles
   task automatic run_set(input logic [M-1:0][N-1:0] v, input string req, output int bcnt);
      @(negedge clk);
      ops_i   = v;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o && !done_o, {req, " R2 busy after start"}, {busy_o, done_o}, 2'b10);
      chk(sum_o == '0, {req, " R4 sum zero while busy"}, sum_o, 0);
      bcnt = 0;
      while (busy_o && bcnt < M + 6) begin
         bcnt++;
         @(negedge clk);
      end
      chk(done_o == 1'b1, {req, " done"}, done_o, 1);
      chk(bcnt <= M + 1, {req, " R5 busy bound"}, bcnt, M + 1);
      chk(longint'(sum_o) == ref_sum(v), {req, " R3 sum"}, sum_o, ref_sum(v));
   endtask

   task automatic t_reset();
      chk(!busy_o && !done_o, "R1 flags after reset", {busy_o, done_o}, 0);
      chk(sum_o == '0, "R1 sum after reset", sum_o, 0);
   endtask

   task automatic t_mixed();
      int b;
      run_set({8'd8, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3, 8'd2, 8'd1}, "mixed_a", b);
      run_set({8'h01, 8'h10, 8'h7E, 8'h81, 8'h00, 8'hFF, 8'h3C, 8'hA5}, "mixed_b", b);
   endtask

   task automatic t_worst();
      int b;
      // operands 4..7 full, 0..3 empty: ones start at the bottom of every column
      run_set({8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h00}, "worst", b);
      chk(b > 1, "R5 bottom-heavy needs several rounds", b, 2);
   endtask

   task automatic t_presorted();
      int b;
      run_set({M{8'h5A}}, "R6 equal", b);
      chk(b == 1, "R6 equal operands one busy cycle", b, 1);
      run_set({M{8'h00}}, "R6 zero", b);
      chk(b == 1, "R6 zero operands one busy cycle", b, 1);
      chk(sum_o == '0, "R6 zero columns count zero", sum_o, 0);
   endtask

   task automatic t_max();
      int b;
      run_set({M{8'hFF}}, "R9 max", b);
      chk(longint'(sum_o) == longint'(M) * 255, "R9 no wrap at max", sum_o, M * 255);
   endtask

   task automatic t_start_busy();
      int b;
      logic [M-1:0][N-1:0] a = {8'hF0, 8'hFF, 8'hFF, 8'h0F, 8'h00, 8'h00, 8'h01, 8'h00};
      @(negedge clk);
      ops_i   = a;
      start_i = 1'b1;
      @(negedge clk);
      ops_i   = {M{8'hFF}};
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      b = 2;
      while (busy_o && b < M + 6) begin
         b++;
         @(negedge clk);
      end
      chk(done_o == 1'b1, "R7 done after ignored start", done_o, 1);
      chk(longint'(sum_o) == ref_sum(a), "R7 result of first set", sum_o, ref_sum(a));
   endtask

   task automatic t_hold_and_restart();
      longint held;
      held = longint'(sum_o);
      repeat (5) @(negedge clk);
      chk(done_o && !busy_o, "R8 done held", {busy_o, done_o}, 1);
      chk(longint'(sum_o) == held, "R8 sum held", sum_o, held);
      // start while done is shown: must be taken at once
      @(negedge clk);
      ops_i   = {8'h00, 8'h01, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00, 8'h01};
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      chk(busy_o && !done_o, "R2 restart from done", {busy_o, done_o}, 2);
      chk(sum_o == '0, "R4 sum cleared on restart", sum_o, 0);
      while (busy_o) @(negedge clk);
      chk(sum_o == SW'(4), "R3 restart sum", sum_o, 4);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_mixed();
      t_worst();
      t_presorted();
      t_max();
      t_start_busy();
      t_hold_and_restart();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule